// File: doc/BRIEF.md
# DMA channel register block

This block holds the software-visible state of one DMA channel: a control/status word, a running transfer address, a byte count and a base address. A CPU reaches it through a 32-bit word slave port with a word address, separate read and write strobes and a registered read-data path. The attached peripheral raises a level interrupt into the block, and the block forwards it to the CPU when software has enabled it. Certain writes to the control/status word have side effects: a one-cycle reset pulse toward the peripheral, a level that enables the peripheral's DMA, and special handling of the drain flag.

The data mover reports each finished transfer with a strobe and a byte count, and the block advances the transfer address by that amount. A parameter selects the network-channel variant. That variant decodes a 32-byte window, ignores accesses above it and does not advance the address on its own.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control/status word reads 0xA0000000, the address, count and base registers read zero, and `cpu_irq`, `periph_rst_pulse` and `dma_en_out` are low.
- R2: Byte-address bits [3:2] select the register: 0 control/status, 1 transfer address, 2 byte count, 3 base address. Higher address bits do not take part in the selection, so addresses alias every 16 bytes inside the decoded window. The standard variant decodes every address.
- R3: One cycle after a cycle with `bus_rd` high, `bus_rdata` holds the selected register as it stood before any write in that same cycle. It holds that value until the next read.
- R4: A control/status write keeps bits 31:25 and 2:0 at their previous values, takes bits 24:3 from the write data, and always reads back 0xA in bits 31:28.
- R5: A control/status write with bit 7 set drives `periph_rst_pulse` high for exactly the following cycle. Bit 7 is stored as written.
- R6: If bit 7 of a control/status write is clear, a written bit 6 (drain) is stored as 0. A write whose whole data word is zero stores bit 6 as 1. If bit 7 is set, bit 6 is stored as written.
- R7: `dma_en_out` follows control/status bit 9. It rises or falls in the cycle after the write that sets or clears that bit.
- R8: A write to the transfer-address register stores the data and sets control/status bit 26. That bit stays set until reset.
- R9: Control/status bit 0 takes the value of `periph_irq_in` sampled on each clock. `cpu_irq` equals bit 0 AND bit 4.
- R10: In the network variant, accesses at byte offsets 0x20 and above are outside the window: a read returns zero and a write changes nothing.
- R11: In the standard variant, `xfer_done` adds `xfer_bytes` to the transfer address. A CPU write to that register in the same cycle takes precedence. The network variant ignores `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| periph_irq_in | input | 1 | Level interrupt from the peripheral |
| cpu_irq | output | 1 | Interrupt toward the CPU |
| periph_rst_pulse | output | 1 | One-cycle reset pulse toward the peripheral |
| dma_en_out | output | 1 | DMA enable level toward the peripheral |
| xfer_done | input | 1 | Data mover finished a transfer |
| xfer_bytes | input | BYTES_W | Bytes moved by that transfer |

## Verification
Both variants receive the same stimulus side by side. Divergence between them separates the window rule and the address advance from the common decode. Directed control/status writes use four data words: all ones, drain alone, all zeros, and drain with reset. Together they separate the three drain cases, the sticky read-only bits and the reset pulse. Further directed steps cover the interrupt input toggling with the enable bit on and off, address writes that collide with transfer completions, and aliased and out-of-window addresses. A long run of pseudo-random accesses, interrupts and transfers then exercises the mixed orderings, with every output compared against a reference model on every cycle.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter bit          ETH_WIN = 1'b0,
  parameter int          ADDR_W  = 8,
  parameter int          BYTES_W = 16,
  parameter logic [3:0]  VERSION = 4'hA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:2]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               periph_irq_in,
  output logic               cpu_irq,
  output logic               periph_rst_pulse,
  output logic               dma_en_out,
  input  logic               xfer_done,
  input  logic [BYTES_W-1:0] xfer_bytes
);
  localparam int B_IEN   = 4;
  localparam int B_DRAIN = 6;
  localparam int B_RST   = 7;
  localparam int B_EN    = 9;
  localparam int CTL_LO  = 3;
  localparam int CTL_HI  = 24;

  logic [ADDR_W-1:4]   hi_bits;
  logic                in_win, csr_wr, adr_wr, cnt_wr, bas_wr;
  logic [1:0]          idx;
  logic [31:0]         wval, csr_word, sel_word;
  logic                pend_q, loaded_q;
  logic [CTL_HI:CTL_LO] ctl_q;
  logic [31:0]         adr_q, cnt_q, bas_q;

  assign hi_bits = bus_addr[ADDR_W-1:4];
  assign in_win  = ETH_WIN ? ((hi_bits >> 1) == '0) : 1'b1;
  assign idx     = bus_addr[3:2];
  assign csr_wr  = bus_wr && in_win && idx == 2'd0;
  assign adr_wr  = bus_wr && in_win && idx == 2'd1;
  assign cnt_wr  = bus_wr && in_win && idx == 2'd2;
  assign bas_wr  = bus_wr && in_win && idx == 2'd3;

  always_comb begin
    wval = bus_wdata;
    if (!wval[B_RST]) begin
      if (wval[B_DRAIN]) wval[B_DRAIN] = 1'b0;
      else if (wval == 32'd0) wval[B_DRAIN] = 1'b1;
    end
  end

  assign csr_word = {VERSION, 1'b0, loaded_q, 1'b0, ctl_q, 2'b00, pend_q};

  always_comb begin
    case (idx)
      2'd0:    sel_word = csr_word;
      2'd1:    sel_word = adr_q;
      2'd2:    sel_word = cnt_q;
      default: sel_word = bas_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q           <= 1'b0;
      loaded_q         <= 1'b0;
      ctl_q            <= '0;
      adr_q            <= '0;
      cnt_q            <= '0;
      bas_q            <= '0;
      bus_rdata        <= '0;
      periph_rst_pulse <= 1'b0;
    end else begin
      pend_q           <= periph_irq_in;
      periph_rst_pulse <= csr_wr && bus_wdata[B_RST];
      if (csr_wr) ctl_q <= wval[CTL_HI:CTL_LO];
      if (adr_wr) begin
        adr_q    <= bus_wdata;
        loaded_q <= 1'b1;
      end else if (!ETH_WIN && xfer_done) begin
        adr_q <= adr_q + 32'(xfer_bytes);
      end
      if (cnt_wr) cnt_q <= bus_wdata;
      if (bas_wr) bas_q <= bus_wdata;
      if (bus_rd) bus_rdata <= in_win ? sel_word : 32'd0;
    end
  end

  assign cpu_irq    = pend_q & ctl_q[B_IEN];
  assign dma_en_out = ctl_q[B_EN];
endmodule

module dma_chan_regs_chk #(
  parameter bit         ETH_WIN = 1'b0,
  parameter int         ADDR_W  = 8,
  parameter logic [3:0] VERSION = 4'hA
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:2] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              periph_irq_in,
  input logic              cpu_irq,
  input logic              periph_rst_pulse,
  input logic              dma_en_out
);
  logic [ADDR_W-1:4] hi;
  logic win, at_csr;
  assign hi     = bus_addr[ADDR_W-1:4];
  assign win    = !ETH_WIN || ((hi >> 1) == '0);
  assign at_csr = win && bus_addr[3:2] == 2'd0;

  // R5
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_pulse == $past(bus_wr && at_csr && bus_wdata[7]));
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(periph_irq_in));
  // R7
  en_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dma_en_out) |-> $past(bus_wr && at_csr));
  // R4
  version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && at_csr) |-> bus_rdata[31:28] == VERSION);
  // R10
  outside_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && !win) |-> bus_rdata == 32'd0);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ETH_WIN(ETH_WIN), .ADDR_W(ADDR_W), .VERSION(VERSION)) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_irq_in(periph_irq_in),
  .cpu_irq(cpu_irq), .periph_rst_pulse(periph_rst_pulse), .dma_en_out(dma_en_out));

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:2]  b_addr = '0;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [31:0] b_wdata = '0;
  logic        irq_in = 1'b0, xd = 1'b0;
  logic [15:0] xb = '0;

  logic [31:0] rd_o [2];
  logic        irq_o [2], pulse_o [2], en_o [2];

  int compared = 0, mismatched = 0;
  bit started = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs #(.ETH_WIN(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(rd_o[0]), .periph_irq_in(irq_in), .cpu_irq(irq_o[0]),
    .periph_rst_pulse(pulse_o[0]), .dma_en_out(en_o[0]), .xfer_done(xd), .xfer_bytes(xb));

  dma_chan_regs #(.ETH_WIN(1'b1)) uut_eth (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(rd_o[1]), .periph_irq_in(irq_in), .cpu_irq(irq_o[1]),
    .periph_rst_pulse(pulse_o[1]), .dma_en_out(en_o[1]), .xfer_done(xd), .xfer_bytes(xb));

  // reference model, one slot per variant: regs[0]=csr, [1]=addr, [2]=count, [3]=base
  logic [31:0] m_reg [2][4];
  logic [31:0] m_rd [2];
  logic        m_pulse [2];

  always @(posedge clk) begin
    started <= 1'b1;
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) begin
        m_reg[v][0] = 32'hA000_0000;
        for (int k = 1; k < 4; k++) m_reg[v][k] = 32'd0;
        m_rd[v] = 32'd0;
        m_pulse[v] = 1'b0;
      end else begin
        int byte_a;
        int sel;
        bit win;
        logic [31:0] val;
        byte_a = {b_addr, 2'b00};
        win = (v == 0) || (byte_a < 32);
        sel = (byte_a / 4) % 4;
        if (b_rd) m_rd[v] = win ? m_reg[v][sel] : 32'd0;
        m_pulse[v] = b_wr && win && sel == 0 && b_wdata[7];
        if (b_wr && win) begin
          if (sel == 0) begin
            val = b_wdata;
            if (!val[7]) begin
              if (val[6]) val[6] = 1'b0;
              else if (val == 0) val = 32'h40;
            end
            m_reg[v][0] = (m_reg[v][0] & 32'hFE00_0007) | (val & ~32'hFE00_0007) | 32'hA000_0000;
          end else begin
            m_reg[v][sel] = b_wdata;
            if (sel == 1) m_reg[v][0][26] = 1'b1;
          end
        end
        if (v == 0 && xd && !(b_wr && sel == 1))
          m_reg[v][1] = m_reg[v][1] + {16'd0, xb};
        m_reg[v][0][0] = irq_in;
      end
    end
  end

  task automatic check1(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      for (int v = 0; v < 2; v++) begin
        check1($sformatf("R1 R2 R3 R4 R6 R8 R10 R11 rdata v%0d", v), rd_o[v], m_rd[v]);
        check1($sformatf("R1 R9 cpu_irq v%0d", v), {31'd0, irq_o[v]},
               {31'd0, m_reg[v][0][0] & m_reg[v][0][4]});
        check1($sformatf("R1 R5 rst_pulse v%0d", v), {31'd0, pulse_o[v]}, {31'd0, m_pulse[v]});
        check1($sformatf("R1 R7 dma_en v%0d", v), {31'd0, en_o[v]}, {31'd0, m_reg[v][0][9]});
      end
    end
  end

  task automatic cyc(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d);
    b_wr = wr; b_rd = rd; b_addr = a[7:2]; b_wdata = d;
    @(negedge clk);
    b_wr = 1'b0; b_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(1'b1, 1'b0, a, d); endtask
  task automatic rd(input logic [7:0] a); cyc(1'b0, 1'b1, a, 32'd0); endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and R2 decode
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
    // R8 address write sets loaded flag
    wr(8'h04, 32'h1234_5678); rd(8'h00); rd(8'h04);
    wr(8'h08, 32'hCAFE_0001); wr(8'h0C, 32'h0000_BEEF); rd(8'h08); rd(8'h0C);
    // R3 read in same cycle as write returns old value
    cyc(1'b1, 1'b1, 8'h08, 32'h0BAD_F00D); rd(8'h08);
    // R4 R5 all ones
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
    // R6 drain cases
    wr(8'h00, 32'h0000_0040); rd(8'h00);
    wr(8'h00, 32'h0000_0000); rd(8'h00);
    wr(8'h00, 32'h0000_00C0); rd(8'h00);
    // R7 R9 enable and interrupt
    wr(8'h00, 32'h0000_0210);
    irq_in = 1'b1; rd(8'h00); rd(8'h00);
    wr(8'h00, 32'h0000_0200); rd(8'h00);
    wr(8'h00, 32'h0000_0010);
    irq_in = 1'b0; rd(8'h00); rd(8'h00);
    wr(8'h00, 32'h0000_0000);
    // R11 transfer advance and collision
    xd = 1'b1; xb = 16'h0020;
    rd(8'h04); rd(8'h04); rd(8'h04);
    wr(8'h04, 32'h0000_1000);
    xd = 1'b0; rd(8'h04);
    // R2 aliasing, R10 window
    wr(8'h44, 32'h0000_0055); rd(8'h04); rd(8'h14); rd(8'h24);
    wr(8'h18, 32'h0000_7777); rd(8'h08); rd(8'h88);
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h00); rd(8'h30);
    // back-to-back reset writes
    wr(8'h00, 32'h80); wr(8'h00, 32'h80); rd(8'h00);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      irq_in = lfsr[3];
      xd = lfsr[5] & lfsr[9];
      xb = lfsr[27:12];
      cyc(lfsr[7], lfsr[8] | lfsr[11],
          lfsr[10] ? {2'b00, lfsr[4], lfsr[2], lfsr[15:14], 2'b00} : {lfsr[19:14], 2'b00},
          lfsr[2] ? {lfsr[13:0], lfsr[31:14]} : (lfsr[6] ? 32'd0 : 32'h40));
    end
    xd = 1'b0; irq_in = 1'b0;
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
    @(negedge clk);
    finish_run();
  end
endmodule